// File: doc/BRIEF.md
# Thread Pick Scheduler for an Eight-Thread Core

This block chooses which hardware threads of an eight-thread core move forward each cycle. A fetch selector looks at all eight threads and grants the ready one that was fetched longest ago. Its grant steers one thread's instruction-buffer fill.

A pick stage issues up to two threads per cycle. The threads form two fixed groups: threads 0 to 3 are group 0, and threads 4 to 7 are group 1. Each group runs its own least-recently-picked arbiter, independent of the other.

The core has one load/store unit and one floating-point unit, and all threads share them. When both picked threads need the same shared unit, only one of them may go. A priority bit settles each such clash and flips after every clash. The group that loses issues nothing that cycle, and its thread keeps its place in the recency order.

All grants are registered. Each grant carries a valid bit and a thread index, and appears one clock after the inputs it was computed from.

Top module: `thread_pick_sched`

## Requirements
- R1: While `rst` is high at a clock edge, every valid output goes low at that edge. After reset, each recency order ranks the lowest thread index as least recent. The clash priority favours group 0.
- R2: When `fetch_vld` is high, `fetch_tid` is the thread whose `fetch_rdy` bit is high and that was granted fetch least recently among those threads.
- R3: A thread is eligible for pick when its `ibuf_nempty` bit is high and its `stall` bit is low. `pick0_tid` is always a thread in 0 to 3, and `pick1_tid` is always a thread in 4 to 7. Each granted thread was eligible.
- R4: Within each group, the eligible thread picked least recently is the candidate. The two groups keep separate recency orders.
- R5: Bit n of `need_lsu` and bit n of `need_fpu` mark thread n as needing the load/store unit or the floating-point unit. Two issued threads in the same cycle never both need the same unit.
- R6: On a clash, the group named by the priority bit keeps its grant. A priority of 0 means group 0. The bit flips after each clash and holds otherwise.
- R7: A recency order moves only for a thread that is actually granted. A candidate that lost a clash keeps its rank.
- R8: Outputs change only at a clock edge. They reflect the inputs sampled at that edge.
- R9: A valid output is low when no thread in its set is eligible. Its thread index is then meaningless.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_rdy | input | 8 | Per-thread fetch-ready |
| ibuf_nempty | input | 8 | Per-thread instruction buffer holds an instruction |
| stall | input | 8 | Per-thread stall |
| need_lsu | input | 8 | Per-thread next instruction needs the load/store unit |
| need_fpu | input | 8 | Per-thread next instruction needs the floating-point unit |
| fetch_vld | output | 1 | Fetch grant valid |
| fetch_tid | output | 3 | Fetch grant thread index |
| pick0_vld | output | 1 | Group 0 pick valid |
| pick0_tid | output | 3 | Group 0 picked thread (0 to 3) |
| pick1_vld | output | 1 | Group 1 pick valid |
| pick1_tid | output | 3 | Group 1 picked thread (4 to 7) |

## Verification
The assertions assume that every input is a known value at every clock edge once reset is released. The shared-unit check reads the need flags of the granted threads only, so it assumes those flags describe the instruction actually being issued.

The stimulus drives every input to a defined value from time zero, including while reset is high. It changes inputs only just after a rising edge. Need flags are set only on threads whose clash behaviour is under test, so each expected grant follows from the recency orders traced by hand.

// File: rtl/tps_pkg.sv
package tps_pkg;

    localparam int NUM_THR = 8;
    localparam int NUM_GRP = 2;
    localparam int GRP_SZ  = NUM_THR / NUM_GRP;
    localparam int TID_W   = $clog2(NUM_THR);
    localparam int LID_W   = $clog2(GRP_SZ);

    typedef logic [TID_W-1:0] tid_t;
    typedef logic [LID_W-1:0] lid_t;

    typedef struct packed {
        logic vld;
        tid_t tid;
    } grant_t;

    // global thread index from a group number and a slot inside that group
    function automatic tid_t to_global(input int grp, input lid_t slot);
        return tid_t'(grp * GRP_SZ) + tid_t'(slot);
    endfunction

endpackage

// File: rtl/tps_lru_arb.sv
// Least-recently-granted arbiter built on an age matrix.
// older[i][j] set means requester i was granted less recently than j.
module tps_lru_arb #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          commit,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);

    logic [N-1:0] older [N];
    logic [N-1:0] gnt_oh;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            gnt_oh[i] = req[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && req[j] && !older[i][j])
                    gnt_oh[i] = 1'b0;
            end
        end
    end

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < N; i++)
            if (gnt_oh[i]) gnt_idx = gnt_idx | IW'(i);
    end

    assign gnt_vld = |gnt_oh;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    older[i][j] <= (i < j);
        end else if (commit && gnt_vld) begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (i != j) begin
                        if (gnt_oh[i])      older[i][j] <= 1'b0;
                        else if (gnt_oh[j]) older[i][j] <= 1'b1;
                    end
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt_oh)); // R4
    AST_GNT_REQ:    assert property (@(posedge clk) disable iff (rst) (gnt_oh & ~req) == '0); // R3

endmodule

// File: rtl/tps_clash.sv
// Resolves the two group candidates against the shared execution units.
module tps_clash
    import tps_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cand_vld,
    input  tid_t               cand_tid0,
    input  tid_t               cand_tid1,
    input  logic [NUM_THR-1:0] need_lsu,
    input  logic [NUM_THR-1:0] need_fpu,
    output logic [1:0]         keep
);

    logic prio_grp1;
    logic clash;

    assign clash = cand_vld[0] && cand_vld[1] &&
                   ((need_lsu[cand_tid0] && need_lsu[cand_tid1]) ||
                    (need_fpu[cand_tid0] && need_fpu[cand_tid1]));

    assign keep[0] = cand_vld[0] && !(clash &&  prio_grp1);
    assign keep[1] = cand_vld[1] && !(clash && !prio_grp1);

    always_ff @(posedge clk) begin
        if (rst)        prio_grp1 <= 1'b0;
        else if (clash) prio_grp1 <= ~prio_grp1;
    end

    AST_CLASH_ONE_KEEP: assert property (@(posedge clk) disable iff (rst) clash |-> $countones(keep) == 1); // R5
    AST_PRIO_FLIP:      assert property (@(posedge clk) disable iff (rst) clash |=> prio_grp1 != $past(prio_grp1)); // R6
    AST_PRIO_HOLD:      assert property (@(posedge clk) disable iff (rst) !clash |=> $stable(prio_grp1)); // R6

endmodule

// File: rtl/thread_pick_sched.sv
module thread_pick_sched
    import tps_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_THR-1:0] fetch_rdy,
    input  logic [NUM_THR-1:0] ibuf_nempty,
    input  logic [NUM_THR-1:0] stall,
    input  logic [NUM_THR-1:0] need_lsu,
    input  logic [NUM_THR-1:0] need_fpu,
    output logic               fetch_vld,
    output logic [TID_W-1:0]   fetch_tid,
    output logic               pick0_vld,
    output logic [TID_W-1:0]   pick0_tid,
    output logic               pick1_vld,
    output logic [TID_W-1:0]   pick1_tid
);

    logic [NUM_THR-1:0] elig;
    logic               f_vld;
    tid_t               f_idx;
    logic [NUM_GRP-1:0] cand_vld;
    tid_t               cand_tid [NUM_GRP];
    logic [NUM_GRP-1:0] keep;
    grant_t             f_q;
    grant_t             p_q [NUM_GRP];

    assign elig = ibuf_nempty & ~stall;

    tps_lru_arb #(.N(NUM_THR)) u_fetch_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (fetch_rdy),
        .commit  (1'b1),
        .gnt_vld (f_vld),
        .gnt_idx (f_idx)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        lid_t slot;
        tps_lru_arb #(.N(GRP_SZ)) u_pick_arb (
            .clk     (clk),
            .rst     (rst),
            .req     (elig[g*GRP_SZ +: GRP_SZ]),
            .commit  (keep[g]),
            .gnt_vld (cand_vld[g]),
            .gnt_idx (slot)
        );
        assign cand_tid[g] = to_global(g, slot);
    end

    tps_clash u_clash (
        .clk       (clk),
        .rst       (rst),
        .cand_vld  (cand_vld),
        .cand_tid0 (cand_tid[0]),
        .cand_tid1 (cand_tid[1]),
        .need_lsu  (need_lsu),
        .need_fpu  (need_fpu),
        .keep      (keep)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
            for (int g = 0; g < NUM_GRP; g++) p_q[g] <= '0;
        end else begin
            f_q.vld <= f_vld;
            f_q.tid <= f_vld ? f_idx : '0;
            for (int g = 0; g < NUM_GRP; g++) begin
                p_q[g].vld <= keep[g];
                p_q[g].tid <= keep[g] ? cand_tid[g] : '0;
            end
        end
    end

    assign fetch_vld = f_q.vld;
    assign fetch_tid = f_q.tid;
    assign pick0_vld = p_q[0].vld;
    assign pick0_tid = p_q[0].tid;
    assign pick1_vld = p_q[1].vld;
    assign pick1_tid = p_q[1].tid;

    // copies of the sampled inputs, aligned with the registered grants
    logic [NUM_THR-1:0] rdy_d, elig_d, lsu_d, fpu_d;
    always_ff @(posedge clk) begin
        rdy_d  <= fetch_rdy;
        elig_d <= elig;
        lsu_d  <= need_lsu;
        fpu_d  <= need_fpu;
    end

    AST_FETCH_ELIG:  assert property (@(posedge clk) disable iff (rst) fetch_vld |-> rdy_d[fetch_tid]); // R2
    AST_FETCH_IDLE:  assert property (@(posedge clk) disable iff (rst) (rdy_d == '0) |-> !fetch_vld); // R9
    AST_PICK0_GROUP: assert property (@(posedge clk) disable iff (rst)
                         pick0_vld |-> (pick0_tid < tid_t'(GRP_SZ)) && elig_d[pick0_tid]); // R3
    AST_PICK1_GROUP: assert property (@(posedge clk) disable iff (rst)
                         pick1_vld |-> (pick1_tid >= tid_t'(GRP_SZ)) && elig_d[pick1_tid]); // R3
    AST_NO_SHARED_CLASH: assert property (@(posedge clk) disable iff (rst)
                         (pick0_vld && pick1_vld) |->
                         !((lsu_d[pick0_tid] && lsu_d[pick1_tid]) ||
                           (fpu_d[pick0_tid] && fpu_d[pick1_tid]))); // R5

endmodule

// File: tb/test_thread_pick_sched.sv
module test_thread_pick_sched;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    // layout: rdy nemp stall lsu fpu | fv ft | p0v p0t | p1v p1t
    localparam logic [51:0] VEC [NV] = '{
        {8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 3'd0, 1'b1, 3'd0, 1'b1, 3'd4}, // R2 R4 reset order
        {8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 3'd1, 1'b1, 3'd1, 1'b1, 3'd5}, // R2 R4
        {8'h81, 8'h0F, 8'h04, 8'h00, 8'h00, 1'b1, 3'd7, 1'b1, 3'd3, 1'b0, 3'd0}, // R3 stall, R9 empty group
        {8'h00, 8'hFF, 8'h00, 8'h44, 8'h00, 1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 3'd0}, // R9 fetch idle, R5 R6 group0 wins
        {8'h00, 8'hFF, 8'h00, 8'h44, 8'h00, 1'b0, 3'd0, 1'b1, 3'd0, 1'b1, 3'd6}, // R7 loser keeps rank
        {8'hFF, 8'hFF, 8'h00, 8'h00, 8'h82, 1'b1, 3'd2, 1'b0, 3'd0, 1'b1, 3'd7}, // R5 R6 group1 wins
        {8'hFF, 8'hFF, 8'h00, 8'h00, 8'h82, 1'b1, 3'd3, 1'b1, 3'd1, 1'b1, 3'd4}, // R7 R4
        {8'h01, 8'hFF, 8'h00, 8'h28, 8'h00, 1'b1, 3'd0, 1'b1, 3'd3, 1'b0, 3'd0}, // R6 back to group0
        {8'hFF, 8'hFF, 8'h00, 8'h04, 8'h20, 1'b1, 3'd4, 1'b1, 3'd2, 1'b1, 3'd5}, // R5 different units
        {8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0}, // R9 all stalled
        {8'h10, 8'hFF, 8'h00, 8'h41, 8'h00, 1'b1, 3'd4, 1'b0, 3'd0, 1'b1, 3'd6}  // R6 priority held
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] fetch_rdy = '0, ibuf_nempty = '0, stall = '0, need_lsu = '0, need_fpu = '0;
    logic       fetch_vld, pick0_vld, pick1_vld;
    logic [2:0] fetch_tid, pick0_tid, pick1_tid;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thread_pick_sched i_thread_pick_sched (
        .clk(clk), .rst(rst),
        .fetch_rdy(fetch_rdy), .ibuf_nempty(ibuf_nempty), .stall(stall),
        .need_lsu(need_lsu), .need_fpu(need_fpu),
        .fetch_vld(fetch_vld), .fetch_tid(fetch_tid),
        .pick0_vld(pick0_vld), .pick0_tid(pick0_tid),
        .pick1_vld(pick1_vld), .pick1_tid(pick1_tid)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] r, input logic [7:0] ne, input logic [7:0] st,
                         input logic [7:0] l, input logic [7:0] f);
        fetch_rdy = r; ibuf_nempty = ne; stall = st; need_lsu = l; need_fpu = f;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_all(input string req, input logic fv, input int ft,
                              input logic p0v, input int p0t, input logic p1v, input int p1t);
        chk(req, "fetch_vld", int'(fetch_vld), int'(fv));
        if (fv) chk(req, "fetch_tid", int'(fetch_tid), ft);
        chk(req, "pick0_vld", int'(pick0_vld), int'(p0v));
        if (p0v) chk(req, "pick0_tid", int'(pick0_tid), p0t);
        chk(req, "pick1_vld", int'(pick1_vld), int'(p1v));
        if (p1v) chk(req, "pick1_tid", int'(pick1_tid), p1t);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: valids held low under reset even with every thread ready
        drive(8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00);
        repeat (3) tick();
        expect_all("R1", 1'b0, 0, 1'b0, 0, 1'b0, 0);
        rst = 1'b0;

        // R8: nothing moves before the next edge
        #2;
        expect_all("R8", 1'b0, 0, 1'b0, 0, 1'b0, 0);

        for (int k = 0; k < NV; k++) begin
            logic [51:0] v;
            v = VEC[k];
            drive(v[51:44], v[43:36], v[35:28], v[27:20], v[19:12]);
            tick();
            chk("R2", "fetch_vld", int'(fetch_vld), int'(v[11]));
            if (v[11]) chk("R2", "fetch_tid", int'(fetch_tid), int'(v[10:8]));
            chk("R4", "pick0_vld", int'(pick0_vld), int'(v[7]));
            if (v[7]) chk("R4", "pick0_tid", int'(pick0_tid), int'(v[6:4]));
            chk("R4", "pick1_vld", int'(pick1_vld), int'(v[3]));
            if (v[3]) chk("R4", "pick1_tid", int'(pick1_tid), int'(v[2:0]));
        end

        // R1: reset mid-run restores orders and the clash priority
        rst = 1'b1;
        tick();
        expect_all("R1", 1'b0, 0, 1'b0, 0, 1'b0, 0);
        rst = 1'b0;
        drive(8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00);
        tick();
        expect_all("R1", 1'b1, 0, 1'b1, 0, 1'b1, 4);
        // R6: first clash after reset goes to group 0
        drive(8'hFF, 8'hFF, 8'h00, 8'h22, 8'h00);
        tick();
        expect_all("R6", 1'b1, 1, 1'b1, 1, 1'b0, 0);
        // R7: thread 5 lost the clash and still heads group 1
        tick();
        expect_all("R7", 1'b1, 2, 1'b1, 2, 1'b1, 5);

        finish_run();
    end

endmodule